// File: doc/BRIEF.md
# Stack Frame Prologue Sequencer

This block carries out the opening of a called routine's stack frame. It takes one command that holds a 12-bit register mask, a 5-bit frame size and the current stack pointer. For each register named in the mask, it reads that register through a register-file read port. It then writes the value as a 32-bit word just below the stack pointer and moves the pointer down by four bytes. After the last push, it lowers the stack pointer by the frame size, which is zero-extended. The block takes one command at a time.

An extended form of the command adds one more cycle. In that cycle the element pointer is loaded from one of four sources, chosen by a 2-bit selector: the final stack pointer, a sign-extended 16-bit immediate, a 16-bit immediate placed in the upper half, or a full 32-bit immediate. The immediates come in with the command. Fetching them is not the block's job.

The mask is scanned from its highest bit to its lowest. The parameter `REG_MAP` gives the register index for each mask bit. The run therefore takes one cycle per selected register, then one allocation cycle, then the optional pointer cycle.

Top module: `frame_prologue_seq`

## Requirements
- R1: After reset `cmd_ready` is 1, `done`, `mem_we` and `ep_we` are 0, and `sp_out` and `ep_out` read 0.
- R2: `cmd_ready` is 1 only while no command is running. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both 1.
- R3: The selected registers are pushed one per cycle, highest mask bit first. Mask bit k reads register `REG_MAP[k]`, which is 20+k by default. `mem_wdata` carries `rf_data` for the index on `rf_addr`.
- R4: Each push writes at the current stack pointer minus 4, and that value becomes the new stack pointer. Successive push addresses step down by exactly 4.
- R5: After the pushes, the stack pointer is lowered by `cmd_imm5`, zero-extended, in bytes.
- R6: In the basic form (`cmd_ext`=0), `done` is raised in cycle N+1 after acceptance, where N is the number of mask bits set. No element-pointer write happens and `ep_out` keeps its value.
- R7: In the extended form, `done` and `ep_we` are raised together in cycle N+2.
- R8: The `cmd_ep_sel` encoding is as follows. 00 gives the stack pointer after the frame size is subtracted. 01 gives `cmd_imm[15:0]` sign-extended. 10 gives `cmd_imm[15:0]` shifted left by 16. 11 gives `cmd_imm` unchanged.
- R9: With an empty mask, no memory write occurs, and `done` comes in cycle 1 (basic form) or cycle 2 (extended form).
- R10: `done` is high for one cycle only. `sp_out` is correct from the `done` cycle on, and both `sp_out` and `ep_out` hold their values until the next command changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_mask | input | 12 | Registers to push |
| cmd_imm5 | input | 5 | Extra frame bytes |
| cmd_ext | input | 1 | Extended form with element-pointer load |
| cmd_ep_sel | input | 2 | Element-pointer source |
| cmd_imm | input | 32 | Immediate for the element pointer |
| sp_in | input | 32 | Stack pointer at command start |
| rf_addr | output | 5 | Register-file read index |
| rf_data | input | 32 | Register-file read data, same cycle |
| mem_we | output | 1 | Word write strobe |
| mem_addr | output | 32 | Word write address |
| mem_wdata | output | 32 | Word write data |
| done | output | 1 | Final-cycle pulse |
| sp_out | output | 32 | Updated stack pointer |
| ep_we | output | 1 | Element-pointer write strobe |
| ep_out | output | 32 | Element pointer |

## Verification
The bench checks push order with sparse and full masks. A scan that ran from the low end, or that used the wrong map entry, would write registers in reversed or shifted order. It counts the cycle of `done` for empty, single-bit, sparse and full masks in both forms, which exposes an off-by-one in the loop exit or an allocation cycle that was dropped or doubled. It uses a negative 16-bit immediate, the upper-half placement and the post-allocation stack pointer, which catch a missing sign extension, swapped selector codes, and an element pointer taken before the frame size was subtracted. Back-to-back commands show that `sp_out` and `ep_out` hold between runs and that a basic-form command leaves the element pointer alone.

// File: rtl/frame_prologue_seq.sv
module frame_prologue_seq #(
  parameter int DATA_W = 32,
  parameter int MASK_W = 12,
  parameter int IMM_W  = 5,
  parameter int RIDX_W = 5,
  parameter logic [MASK_W*RIDX_W-1:0] REG_MAP = {
    5'd31, 5'd30, 5'd29, 5'd28, 5'd27, 5'd26,
    5'd25, 5'd24, 5'd23, 5'd22, 5'd21, 5'd20}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [MASK_W-1:0] cmd_mask,
  input  logic [IMM_W-1:0]  cmd_imm5,
  input  logic              cmd_ext,
  input  logic [1:0]        cmd_ep_sel,
  input  logic [DATA_W-1:0] cmd_imm,
  input  logic [DATA_W-1:0] sp_in,
  output logic [RIDX_W-1:0] rf_addr,
  input  logic [DATA_W-1:0] rf_data,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done,
  output logic [DATA_W-1:0] sp_out,
  output logic              ep_we,
  output logic [DATA_W-1:0] ep_out
);
  localparam int IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;
  localparam int HALF  = DATA_W / 2;

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_ALLOC, S_EPLD} state_t;

  state_t              state;
  logic [MASK_W-1:0]   mask_r;
  logic [IMM_W-1:0]    imm5_r;
  logic                ext_r;
  logic [1:0]          sel_r;
  logic [DATA_W-1:0]   imm_r;
  logic [DATA_W-1:0]   sp_r;
  logic [DATA_W-1:0]   ep_r;
  logic [IDX_W-1:0]    top_idx;
  logic [MASK_W-1:0]   mask_left;
  logic [DATA_W-1:0]   frame_sz;
  logic [DATA_W-1:0]   ep_next;
  logic                accept;

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < MASK_W; i++)
      if (mask_r[i]) top_idx = IDX_W'(i);
  end

  always_comb begin
    mask_left = mask_r;
    mask_left[top_idx] = 1'b0;
  end

  always_comb begin
    unique case (sel_r)
      2'b00:   ep_next = sp_r;
      2'b01:   ep_next = {{(DATA_W-HALF){imm_r[HALF-1]}}, imm_r[HALF-1:0]};
      2'b10:   ep_next = {imm_r[HALF-1:0], {(DATA_W-HALF){1'b0}}};
      default: ep_next = imm_r;
    endcase
  end

  assign frame_sz  = {{(DATA_W-IMM_W){1'b0}}, imm5_r};
  assign accept    = cmd_valid && cmd_ready;
  assign cmd_ready = (state == S_IDLE);
  assign rf_addr   = REG_MAP[top_idx*RIDX_W +: RIDX_W];
  assign mem_we    = (state == S_PUSH);
  assign mem_addr  = sp_r - DATA_W'(4);
  assign mem_wdata = rf_data;
  assign done      = (state == S_EPLD) || (state == S_ALLOC && !ext_r);
  assign ep_we     = (state == S_EPLD);
  assign sp_out    = (state == S_ALLOC) ? sp_r - frame_sz : sp_r;
  assign ep_out    = (state == S_EPLD) ? ep_next : ep_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      mask_r <= '0;
      imm5_r <= '0;
      ext_r  <= 1'b0;
      sel_r  <= 2'b00;
      imm_r  <= '0;
      sp_r   <= '0;
      ep_r   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          mask_r <= cmd_mask;
          imm5_r <= cmd_imm5;
          ext_r  <= cmd_ext;
          sel_r  <= cmd_ep_sel;
          imm_r  <= cmd_imm;
          sp_r   <= sp_in;
          state  <= (cmd_mask != '0) ? S_PUSH : S_ALLOC;
        end
        S_PUSH: begin
          sp_r   <= sp_r - DATA_W'(4);
          mask_r <= mask_left;
          if (mask_left == '0) state <= S_ALLOC;
        end
        S_ALLOC: begin
          sp_r  <= sp_r - frame_sz;
          state <= ext_r ? S_EPLD : S_IDLE;
        end
        default: begin
          ep_r  <= ep_next;
          state <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/frame_prologue_seq_chk.sv
module frame_prologue_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        done,
  input logic        ep_we,
  input logic [31:0] sp_out,
  input logic [31:0] ep_out
);
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) - 32'd4); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_we && !done && !ep_we); // R2
  AST_EP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ep_we |-> done); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready && $past(cmd_ready) |-> $stable(sp_out) && $stable(ep_out)); // R10
  AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cmd_ready); // R2
endmodule

bind frame_prologue_seq frame_prologue_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .done(done), .ep_we(ep_we),
  .sp_out(sp_out), .ep_out(ep_out)
);

// File: tb/frame_prologue_seq_test.sv
module frame_prologue_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [11:0] cmd_mask = '0;
  logic [4:0]  cmd_imm5 = '0;
  logic        cmd_ext = 1'b0;
  logic [1:0]  cmd_ep_sel = '0;
  logic [31:0] cmd_imm = '0;
  logic [31:0] sp_in = '0;
  logic [4:0]  rf_addr;
  logic [31:0] rf_data;
  logic        mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        done, ep_we;
  logic [31:0] sp_out, ep_out;

  int checks = 0;
  int fails  = 0;
  logic [31:0] ep_model = '0;

  always #5 clk = ~clk;

  assign rf_data = 32'h5000_0000 | {27'd0, rf_addr} | ({27'd0, rf_addr} << 12);

  frame_prologue_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mask(cmd_mask), .cmd_imm5(cmd_imm5), .cmd_ext(cmd_ext),
    .cmd_ep_sel(cmd_ep_sel), .cmd_imm(cmd_imm), .sp_in(sp_in),
    .rf_addr(rf_addr), .rf_data(rf_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done),
    .sp_out(sp_out), .ep_we(ep_we), .ep_out(ep_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] reg_val(input int idx);
    return 32'h5000_0000 | idx | (idx << 12);
  endfunction

  task automatic run_case(input logic [11:0] mask, input logic [4:0] imm5,
                          input bit ext, input logic [1:0] sel,
                          input logic [31:0] imm, input logic [31:0] sp0);
    int regs[12];
    int n = 0;
    int pushes = 0;
    int cyc = 0;
    logic [31:0] sp_exp, ep_exp;
    for (int b = 11; b >= 0; b--) if (mask[b]) begin regs[n] = 20 + b; n++; end
    sp_exp = sp0 - 32'd4 * n - {27'd0, imm5};
    case (sel)
      2'b00: ep_exp = sp_exp;
      2'b01: ep_exp = {{16{imm[15]}}, imm[15:0]};
      2'b10: ep_exp = {imm[15:0], 16'h0};
      default: ep_exp = imm;
    endcase
    if (!ext) ep_exp = ep_model;
    @(negedge clk);
    check(cmd_ready === 1'b1, "R2 ready before command", 32'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_mask = mask; cmd_imm5 = imm5; cmd_ext = ext;
    cmd_ep_sel = sel; cmd_imm = imm; sp_in = sp0;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_mask = 12'hfff; cmd_imm = 32'hdead_beef; sp_in = 32'h0bad_0000;
    check(cmd_ready === 1'b0, "R2 busy after accept", 32'(cmd_ready), 0);
    for (int k = 1; k <= 40; k++) begin
      cyc = k;
      if (mem_we) begin
        if (pushes < n) begin
          check(mem_addr == sp0 - 32'd4 * (pushes + 1), "R4 push address", mem_addr,
                sp0 - 32'd4 * (pushes + 1));
          check(rf_addr == 5'(regs[pushes]), "R3 push order", 32'(rf_addr), regs[pushes]);
          check(mem_wdata == reg_val(regs[pushes]), "R3 push data", mem_wdata,
                reg_val(regs[pushes]));
        end
        pushes++;
      end
      if (done) break;
      @(negedge clk);
    end
    check(pushes == n, (n == 0) ? "R9 no writes for empty mask" : "R3 push count",
          pushes, n);
    check(cyc == n + 1 + int'(ext), ext ? "R7 extended cycle count" :
          (n == 0 ? "R9 empty-mask cycle count" : "R6 basic cycle count"),
          cyc, n + 1 + int'(ext));
    check(sp_out == sp_exp, "R5 final stack pointer", sp_out, sp_exp);
    check(ep_we === ext, ext ? "R7 ep write with done" : "R6 no ep write", 32'(ep_we),
          32'(ext));
    if (ext) check(ep_out == ep_exp, "R8 element pointer source", ep_out, ep_exp);
    @(negedge clk);
    check(done === 1'b0, "R10 done one cycle", 32'(done), 0);
    check(sp_out == sp_exp, "R10 stack pointer held", sp_out, sp_exp);
    check(ep_out == ep_exp, ext ? "R10 ep held" : "R6 ep unchanged", ep_out, ep_exp);
    check(cmd_ready === 1'b1, "R2 ready after done", 32'(cmd_ready), 1);
    ep_model = ep_exp;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(cmd_ready === 1'b1, "R1 ready", 32'(cmd_ready), 1);
    check(done === 1'b0 && mem_we === 1'b0 && ep_we === 1'b0, "R1 strobes low",
          {29'd0, done, mem_we, ep_we}, 0);
    check(sp_out == 0 && ep_out == 0, "R1 pointers zero", sp_out | ep_out, 0);
  endtask

  task automatic t_idle_no_accept();
    repeat (3) @(negedge clk);
    check(sp_out == ep_model - ep_model + sp_out && !done, "R2 no start without valid",
          32'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_idle_no_accept();
    run_case(12'hfff, 5'd31, 1'b0, 2'b00, 32'h0, 32'h0000_8000);
    run_case(12'h000, 5'd8,  1'b0, 2'b00, 32'h0, 32'h0000_1000);
    run_case(12'h000, 5'd4,  1'b1, 2'b00, 32'h0, 32'h0000_2000);
    run_case(12'h813, 5'd12, 1'b1, 2'b01, 32'h1234_8004, 32'h0001_0000);
    run_case(12'h040, 5'd0,  1'b1, 2'b10, 32'h0000_abcd, 32'h0000_0400);
    run_case(12'h0a0, 5'd16, 1'b1, 2'b11, 32'hcafe_f00d, 32'h0000_0800);
    run_case(12'h401, 5'd3,  1'b0, 2'b11, 32'h1111_1111, 32'h0000_0c00);
    run_case(12'h002, 5'd1,  1'b1, 2'b00, 32'h0, 32'h0000_0100);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule